// File: doc/BRIEF.md
# Two-Wire Serial Memory Target with Address Latch

This block is a target on a two-wire serial bus (one clock line and one open-drain data line) that gives a master byte-wide access to an internal register array. A transaction begins with a device header: a 7-bit device address followed by a direction bit. A write header is followed by a two-byte memory address, high byte first, and then any number of data bytes. A read header returns data starting from an internal address latch. The latch keeps its value between transactions. That value always points one past the last byte stored or fetched, so a master can keep reading from where the previous access ended.

To read from an arbitrary location, the master sends a write header and the two address bytes, then a repeated Start and a read header. Both bus lines are oversampled on the system clock through a synchronizer. The block detects Start, Stop and clock edges itself. It pulls SDA low only while SCL is low, or releases it at once on a bus condition. The memory depth is a power-of-two parameter. Address bits above the array index are dropped.

Top module: `twi_mem_target`

## Requirements
- R1: The block answers only a header whose upper seven bits equal DEV_ADDR. For any other header it does not acknowledge, does not drive SDA and leaves the memory and the address latch untouched until the next Start.
- R2: A header with bit 0 equal to 0 is a write. The block acknowledges the header, each of the two address bytes and every data byte by holding SDA low during the 9th clock. A single data byte is stored at the loaded address.
- R3: Consecutive data bytes in one write are stored at consecutive addresses, and every one of them is acknowledged.
- R4: A header with bit 0 equal to 1 is a read. The first byte returned, MSB first, comes from the address latch, which holds the address after the last byte written or read.
- R5: While the master acknowledges each byte in the 9th clock, the block returns the bytes at successive addresses.
- R6: After address MEM_DEPTH-1, the latch wraps to 0. This holds for both reads and writes.
- R7: A write header carrying two address bytes loads the latch, and a repeated Start with a read header then returns data from the loaded address.
- R8: A read ends and SDA is released after any of these: a NACK followed by Stop, a NACK followed by Start, a Stop inside the 9th clock, or a Start inside the 9th clock.
- R9: A Start or Stop that arrives before a data byte's 9th clock begins discards the partial byte. Memory is not changed.
- R10: SDA drive changes only while SCL is low, except that it is released on any Start or Stop. After reset the block does not drive SDA.
- R11: Of the two address bytes, only the low log2(MEM_DEPTH) bits select the location. Higher bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions check the timing rules on every cycle. They check that SDA drive changes only after SCL has been seen low or on a bus condition. They check that the block is silent in every receive, idle and master-acknowledge state. They check that every stored byte is followed by an acknowledge. They check that the address latch steps by one, wraps at the top or holds still. The bench's scenarios show what depends on byte content and on sequence. These include the data returned across a full sweep with wraparound, the selective read through a repeated Start, the four ways a read can end, the discarding of partial bytes, and the fact that foreign-address traffic leaves the latch and the memory alone.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  localparam int unsigned BYTE_BITS = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_sync_q;
  logic [STAGES-1:0] sda_sync_q;
  logic              scl_prev_q;
  logic              sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_sync_q[STAGES-1];
      sda_prev_q <= sda_sync_q[STAGES-1];
    end
  end

  assign scl_o      = scl_sync_q[STAGES-1];
  assign sda_o      = sda_sync_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_o & scl_prev_q;
  // data edges with the clock held high on both samples
  assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
  assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/twi_addr_latch.sv
module twi_addr_latch #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] addr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= load_val_i;
    end else if (inc_i) begin
      addr_q <= (addr_q == LAST) ? '0 : addr_q + IDX_W'(1);
    end
  end

  assign addr_o = addr_q;

  AST_LAT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && addr_q == LAST) |=> addr_q == '0); // R6
  AST_LAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && addr_q != LAST) |=> addr_q == $past(addr_q) + IDX_W'(1)); // R5
  AST_LAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(addr_q)); // R4

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target
  import twi_mem_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned MEM_DEPTH   = 256,   // power of two, at most 65536
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  localparam int unsigned IDX_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(BYTE_BITS) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  twi_state_e       state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [7:0]       rx_q;
  logic [7:0]       tx_q;
  logic             rw_q;
  logic             mack_q;
  logic             oe_q;

  logic             byte_done;
  logic             quiet;
  logic             lat_load, lat_inc, mem_we;
  logic [IDX_W-1:0] addr;
  logic [IDX_W-1:0] load_val;
  logic [7:0]       rd_data;

  twi_line_sync #(
    .STAGES(SYNC_STAGES)
  ) i_line_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  assign byte_done = scl_fall && (bit_cnt_q == CNT_FULL);
  assign quiet     = !bus_start && !bus_stop;

  // state that acknowledges a received byte, and the receive state after it
  function automatic twi_state_e ack_state(input twi_state_e s);
    case (s)
      ST_DEV:  return ST_DEV_ACK;
      ST_AHI:  return ST_AHI_ACK;
      ST_ALO:  return ST_ALO_ACK;
      default: return ST_WR_ACK;
    endcase
  endfunction

  function automatic twi_state_e rx_after(input twi_state_e s);
    case (s)
      ST_DEV_ACK: return ST_AHI;
      ST_AHI_ACK: return ST_ALO;
      default:    return ST_WR;
    endcase
  endfunction

  // upper address byte only kept when the array needs it
  if (IDX_W > 8) begin : g_hi
    logic [IDX_W-9:0] hi_q;
    logic             hi_load;
    assign hi_load = quiet && (state_q == ST_AHI) && byte_done;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hi_q <= '0;
      else if (hi_load) hi_q <= rx_q[IDX_W-9:0];
    end
    assign load_val = {hi_q, rx_q};
  end else begin : g_nohi
    assign load_val = rx_q[IDX_W-1:0];
  end

  always_comb begin
    lat_load = 1'b0;
    lat_inc  = 1'b0;
    mem_we   = 1'b0;
    if (quiet) begin
      case (state_q)
        ST_ALO:     lat_load = byte_done;
        ST_WR: begin
          mem_we  = byte_done;
          lat_inc = byte_done;
        end
        ST_DEV_ACK: lat_inc = scl_fall && rw_q;
        ST_RD_ACK:  lat_inc = scl_fall && mack_q;
        default: ;
      endcase
    end
  end

  twi_addr_latch #(
    .DEPTH(MEM_DEPTH),
    .IDX_W(IDX_W)
  ) i_addr_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (lat_load),
    .load_val_i(load_val),
    .inc_i     (lat_inc),
    .addr_o    (addr)
  );

  twi_mem_array #(
    .DEPTH(MEM_DEPTH),
    .IDX_W(IDX_W)
  ) i_mem_array (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .addr_i (addr),
    .wdata_i(rx_q),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
    end else if (bus_start) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (bus_stop) begin
      state_q   <= ST_IDLE;
      oe_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
          if (scl_rise) begin
            rx_q      <= {rx_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            if (state_q == ST_DEV && rx_q[7:1] != DEV_ADDR) begin
              state_q <= ST_IDLE;
            end else begin
              oe_q    <= 1'b1;
              state_q <= ack_state(state_q);
              if (state_q == ST_DEV) rw_q <= rx_q[0];
            end
          end
        end
        ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            if (state_q == ST_DEV_ACK && rw_q) begin
              tx_q    <= rd_data;
              oe_q    <= ~rd_data[7];
              state_q <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              state_q <= rx_after(state_q);
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
          end else if (scl_fall) begin
            if (bit_cnt_q == CNT_FULL) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_RD_ACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_q    <= rd_data;
              oe_q    <= ~rd_data[7];
              state_q <= ST_RD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> (!$past(scl_s) || $past(bus_start || bus_stop))); // R10
  AST_EVENT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_start || bus_stop) |=> !oe_q); // R8
  AST_SILENT_STATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD_ACK}) |-> !oe_q); // R1
  AST_STORE_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> (oe_q && state_q == ST_WR_ACK)); // R2

endmodule

// File: tb/test_twi_mem_target.sv
module test_twi_mem_target;

  localparam logic [6:0] DEV   = 7'h50;
  localparam int         DEPTH = 64;
  localparam int         Q     = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic scl;
  logic m_low;
  logic sda_oe_o;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int oe_viol = 0;
  logic oe_prev = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = !(m_low || sda_oe_o);

  twi_mem_target #(
    .DEV_ADDR (DEV),
    .MEM_DEPTH(DEPTH)
  ) i_twi_mem_target (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_line),
    .sda_oe_o(sda_oe_o)
  );

  function automatic int f(input int a);
    return (a * 37 + 11) & 255;
  endfunction

  // drive changes while the clock line is high, outside Start/Stop, are forbidden
  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe_o != oe_prev)) oe_viol++;
    oe_prev <= sda_oe_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; hold();
    scl = 1'b1;   hold();
    m_low = 1'b1; hold();
    scl = 1'b0;   hold();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; hold();
    scl = 1'b1;   hold();
    m_low = 1'b0; hold(); hold();
  endtask

  task automatic send_bit(input logic b);
    m_low = !b; hold();
    scl = 1'b1; hold(); hold();
    scl = 1'b0; hold();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    m_low = 1'b0; hold();
    scl = 1'b1;   hold();
    ack = !sda_line; hold();
    scl = 1'b0;   hold();
  endtask

  task automatic recv_bits(output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hold();
      scl = 1'b1; hold();
      d[i] = sda_line; hold();
      scl = 1'b0;
    end
    hold();
  endtask

  logic       a;
  logic [7:0] d;

  initial begin
    scl = 1'b1; m_low = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 reset drive", sda_oe_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // full sweep write from address 0
    i2c_start();
    send_byte({DEV, 1'b0}, a); chk("R2 write header ack", a, 1);
    send_byte(8'h00, a);       chk("R2 addr hi ack", a, 1);
    send_byte(8'h00, a);       chk("R2 addr lo ack", a, 1);
    for (int i = 0; i < DEPTH; i++) begin
      send_byte(8'(f(i)), a);
      chk("R3 data ack", a, 1);
    end
    i2c_stop();

    // current-address read continues after write wrap, then wraps again
    i2c_start();
    send_byte({DEV, 1'b1}, a); chk("R4 read header ack", a, 1);
    for (int i = 0; i <= DEPTH; i++) begin
      recv_bits(d);
      if (i == 0)          chk("R6 R4 first byte after write wrap", d, f(0));
      else if (i == DEPTH) chk("R6 read wrap", d, f(0));
      else                 chk("R5 sequential byte", d, f(i));
      send_bit(i == DEPTH);
    end
    i2c_stop();
    chk("R8 nack then stop release", sda_oe_o, 0);

    // foreign device address
    i2c_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a); chk("R1 foreign header nack", a, 0);
    send_byte(8'h00, a);               chk("R1 foreign byte nack", a, 0);
    send_byte(8'h01, a);               chk("R1 foreign byte nack", a, 0);
    send_byte(8'hFF, a);               chk("R1 foreign data nack", a, 0);
    i2c_stop();
    i2c_start();
    send_byte({DEV ^ 7'h01, 1'b1}, a); chk("R1 foreign read nack", a, 0);
    recv_bits(d);                      chk("R1 foreign read no drive", d, 8'hFF);
    send_bit(1'b1);
    i2c_stop();
    i2c_start();
    send_byte({DEV, 1'b1}, a);
    recv_bits(d); chk("R1 latch untouched by foreign traffic", d, f(1));
    send_bit(1'b1);
    i2c_stop();
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a); send_byte(8'h01, a);
    i2c_start();
    send_byte({DEV, 1'b1}, a);
    recv_bits(d); chk("R1 memory untouched by foreign write", d, f(1));
    send_bit(1'b1);
    i2c_stop();

    // selective read with upper address bits set
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h12, a);
    send_byte(8'h50, a);
    i2c_start();
    send_byte({DEV, 1'b1}, a); chk("R7 read header after repeated start", a, 1);
    recv_bits(d); chk("R7 R11 selective byte", d, f(8'h10));
    send_bit(1'b1);
    i2c_start();
    chk("R8 nack then start release", sda_oe_o, 0);
    send_byte({DEV, 1'b1}, a);
    recv_bits(d); chk("R4 current after selective", d, f(8'h11));
    i2c_stop();
    chk("R8 stop in ninth clock release", sda_oe_o, 0);
    i2c_start();
    send_byte({DEV, 1'b1}, a);
    recv_bits(d); chk("R4 current after stop-in-ninth", d, f(8'h12));
    i2c_start();
    chk("R8 start in ninth clock release", sda_oe_o, 0);
    send_byte({DEV, 1'b1}, a); chk("R8 header after start in ninth", a, 1);
    recv_bits(d); chk("R4 current after start-in-ninth", d, f(8'h13));
    send_bit(1'b1);
    i2c_stop();

    // single-byte write and readback
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h20, a);
    send_byte(8'h5A, a); chk("R2 single data ack", a, 1);
    i2c_stop();
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h20, a);
    i2c_start();
    send_byte({DEV, 1'b1}, a);
    recv_bits(d); chk("R2 single byte stored", d, 8'h5A);
    send_bit(1'b1);
    i2c_stop();

    // partial byte cut by a Stop inside the 8th bit
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h21, a);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    i2c_stop();
    i2c_start();
    send_byte({DEV, 1'b1}, a);
    recv_bits(d); chk("R9 stop discards partial byte", d, f(8'h21));
    send_bit(1'b1);
    i2c_stop();

    // partial byte cut by a Start
    i2c_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h22, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    i2c_start();
    send_byte({DEV, 1'b1}, a);
    recv_bits(d); chk("R9 start discards partial byte", d, f(8'h22));
    send_bit(1'b1);
    i2c_stop();

    chk("R10 no drive change while clock high", oe_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule